// File: doc/BRIEF.md
# Strobe Delay-Locked Loop Controller

This block is the digital half of a delay-locked loop that places read-strobe sampling points for an external memory interface. A 6-bit period code drives an external delay chain. An external phase comparator looks at the reference clock and the chain's delayed copy and says, on each update, whether the chain is too short (step up) or too long (step down). The counter walks the code one step at a time until the chain spans one full reference period. At that point the comparator answer flips on every update, and the block reports lock.

From the period code, the block derives one shift code for the strobe delay elements. A quarter of the period gives a 90 degree shift and a fifth gives 72 degrees. Selecting 0 degrees forces the code to zero and raises a bypass flag. That single result is copied to every strobe lane on the side.

Software or a sequencer drops the freeze input high while read data is being captured, so that loop jitter cannot move a strobe in the middle of a burst. It releases freeze in a quiet window, such as a refresh, to let the loop track again. Dropping the enable stops the loop entirely and clears the lock indication.

Top module: `strobe_dll_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the period code is 0 and the lock flag is 0.
- R2: While enable is 1 and freeze is 0, one update occurs every UPD_INTERVAL reference cycles (default 2). The first update comes UPD_INTERVAL cycles after enable rises. On each update the code moves by exactly one step: up when the early_late input is 1, down when it is 0.
- R3: The code saturates. An up step at 63 leaves it at 63, and a down step at 0 leaves it at 0.
- R4: The comparator reports 1 whenever the code is below the chain target P, for any P from 1 to 63. Starting from reset, the lock flag rises within 256 cycles of enable, and the code is then P or P-1.
- R5: The lock flag rises on the update that completes 4 consecutive direction reversals, which means 5 updates in alternating directions. It then stays high until enable falls or reset is applied.
- R6: Enable at 0 stops updates and holds the code. The lock flag is 0 from the next cycle on, and the reversal history restarts when enable returns.
- R7: Freeze at 1 with enable at 1 holds both the code and the lock flag. Releasing freeze resumes tracking from the held code.
- R8: The phase_sel encoding is as follows. 2'b10 selects 90 degrees and gives (code+2)/4, rounded to nearest. 2'b01 selects 72 degrees and gives (code+2)/5, rounded to nearest. 2'b00 and 2'b11 select 0 degrees, giving a shift of 0 with bypass at 1. Bypass is 0 for the other two values. The shift output follows phase_sel and the code in the same cycle.
- R9: Each of the NUM_STROBES lanes carries the same shift code. Lane i sits at bits [6*i+5 : 6*i] of shift_codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Loop enable; low stops updates and clears lock |
| freeze | input | 1 | Holds code and lock, for use during read capture |
| early_late | input | 1 | Comparator result: 1 = chain too short, step up |
| phase_sel | input | 2 | Shift select: 00/11 = 0 deg, 01 = 72 deg, 10 = 90 deg |
| period_code | output | 6 | Delay code to the reference delay chain |
| shift_codes | output | 60 | Shift code for each of 10 strobe lanes, 6 bits per lane |
| bypass | output | 1 | High when 0 degrees is selected |
| locked | output | 1 | Loop lock indication |

## Verification
The bench uses the default build: a 6-bit code, ten lanes and an update every two cycles. With that build, every chain target from 1 to 63 can be swept, and the worst-case lock latency is checked against the 256-cycle limit. Each target is frozen once it is locked, and the four phase_sel values are applied. This places the scaling check on nearly every code value and every lane. Targets above the range and at zero drive the counter into both saturation rails.

// File: rtl/dll_pkg.sv
package dll_pkg;

    typedef enum logic [1:0] {
        PH_ZERO = 2'b00,
        PH_72   = 2'b01,
        PH_90   = 2'b10,
        PH_RSVD = 2'b11
    } phase_sel_e;

    typedef struct packed {
        logic valid;
        logic up;
    } step_ev_t;

    function automatic int unsigned round_div(input int unsigned num, input int unsigned den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/dll_step_counter.sv
module dll_step_counter
    import dll_pkg::*;
#(
    parameter int CODE_W       = 6,
    parameter int UPD_INTERVAL = 2,
    parameter int RESET_CODE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic              up_req,
    output logic [CODE_W-1:0] code,
    output step_ev_t          step_ev
);
    localparam int TMR_W = (UPD_INTERVAL > 1) ? $clog2(UPD_INTERVAL) : 1;
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(UPD_INTERVAL - 1);

    logic [TMR_W-1:0]  tmr_q;
    logic [CODE_W-1:0] code_q;
    logic              tick;

    assign tick = run && (tmr_q == TMR_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tmr_q <= '0;
        end else if (run) begin
            tmr_q <= tick ? '0 : tmr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= CODE_W'(RESET_CODE);
        end else if (tick) begin
            if (up_req && code_q != CODE_MAX) begin
                code_q <= code_q + 1'b1;
            end else if (!up_req && code_q != '0) begin
                code_q <= code_q - 1'b1;
            end
        end
    end

    assign code          = code_q;
    assign step_ev.valid = tick;
    assign step_ev.up    = up_req;

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (code_q == $past(code_q)) ||
        ({1'b0, code_q} == {1'b0, $past(code_q)} + 1'b1) ||
        ({1'b0, code_q} + 1'b1 == {1'b0, $past(code_q)}));

    assert_sat_high_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && up_req && code_q == CODE_MAX) |=> (code_q == CODE_MAX));

    assert_sat_low_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !up_req && code_q == '0) |=> (code_q == '0));

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(code_q));

endmodule

// File: rtl/dll_lock_detect.sv
module dll_lock_detect
    import dll_pkg::*;
#(
    parameter int ALT_NEEDED = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  step_ev_t step_ev,
    output logic     locked
);
    localparam int AW = $clog2(ALT_NEEDED + 1);
    localparam logic [AW-1:0] ALT_TOP = AW'(ALT_NEEDED);

    logic          have_prev_q;
    logic          prev_up_q;
    logic [AW-1:0] alt_q;
    logic [AW-1:0] alt_next;
    logic          locked_q;

    always_comb begin
        if (have_prev_q && (step_ev.up != prev_up_q)) begin
            alt_next = (alt_q == ALT_TOP) ? alt_q : alt_q + 1'b1;
        end else begin
            alt_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            have_prev_q <= 1'b0;
            prev_up_q   <= 1'b0;
            alt_q       <= '0;
            locked_q    <= 1'b0;
        end else if (step_ev.valid) begin
            have_prev_q <= 1'b1;
            prev_up_q   <= step_ev.up;
            alt_q       <= alt_next;
            if (alt_next == ALT_TOP) begin
                locked_q <= 1'b1;
            end
        end
    end

    assign locked = locked_q;

    assert_lock_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> !locked_q);

    assert_lock_on_update_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> $past(step_ev.valid));

endmodule

// File: rtl/dll_phase_scaler.sv
module dll_phase_scaler
    import dll_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] code,
    input  phase_sel_e        sel,
    output logic [CODE_W-1:0] shift,
    output logic              bypass
);
    always_comb begin
        unique case (sel)
            PH_72: begin
                shift  = CODE_W'(round_div(32'(code), 5));
                bypass = 1'b0;
            end
            PH_90: begin
                shift  = CODE_W'(round_div(32'(code), 4));
                bypass = 1'b0;
            end
            default: begin
                shift  = '0;
                bypass = 1'b1;
            end
        endcase
    end

    always_comb begin
        assert_bypass_zero_R8: assert (!bypass || shift == '0);
    end

endmodule

// File: rtl/strobe_dll_ctrl.sv
module strobe_dll_ctrl
    import dll_pkg::*;
#(
    parameter int CODE_W       = 6,
    parameter int NUM_STROBES  = 10,
    parameter int UPD_INTERVAL = 2,
    parameter int ALT_NEEDED   = 4,
    parameter int RESET_CODE   = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          enable,
    input  logic                          freeze,
    input  logic                          early_late,
    input  logic [1:0]                    phase_sel,
    output logic [CODE_W-1:0]             period_code,
    output logic [NUM_STROBES*CODE_W-1:0] shift_codes,
    output logic                          bypass,
    output logic                          locked
);
    logic              run;
    logic              clr;
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] shift;
    step_ev_t          step_ev;
    phase_sel_e        sel;

    assign run = enable && !freeze;
    assign clr = !enable;
    assign sel = phase_sel_e'(phase_sel);

    dll_step_counter #(
        .CODE_W       (CODE_W),
        .UPD_INTERVAL (UPD_INTERVAL),
        .RESET_CODE   (RESET_CODE)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .run     (run),
        .up_req  (early_late),
        .code    (code),
        .step_ev (step_ev)
    );

    dll_lock_detect #(
        .ALT_NEEDED (ALT_NEEDED)
    ) u_lock (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .step_ev (step_ev),
        .locked  (locked)
    );

    dll_phase_scaler #(
        .CODE_W (CODE_W)
    ) u_scaler (
        .code   (code),
        .sel    (sel),
        .shift  (shift),
        .bypass (bypass)
    );

    for (genvar lane = 0; lane < NUM_STROBES; lane++) begin : g_lane
        assign shift_codes[lane*CODE_W +: CODE_W] = shift;
    end

    assign period_code = code;

    assert_frozen_lock_held_R7: assert property (@(posedge clk) disable iff (rst)
        (enable && freeze && $past(enable)) |=> $stable(locked));

endmodule

// File: tb/strobe_dll_ctrl_bench.sv
module strobe_dll_ctrl_bench;
    localparam int W  = 6;
    localparam int NS = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic freeze = 1'b0;
    logic early_late;
    logic [1:0] phase_sel = 2'b00;
    logic [W-1:0] period_code;
    logic [NS*W-1:0] shift_codes;
    logic bypass;
    logic locked;
    int target = 0;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign early_late = (int'(period_code) < target);

    strobe_dll_ctrl u_strobe_dll_ctrl (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .freeze      (freeze),
        .early_late  (early_late),
        .phase_sel   (phase_sel),
        .period_code (period_code),
        .shift_codes (shift_codes),
        .bypass      (bypass),
        .locked      (locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        enable = 1'b0;
        freeze = 1'b0;
        cycles(2);
        rst = 1'b0;
    endtask

    function automatic int exp_shift(input int c, input int sel);
        if (sel == 1) return (c + 2) / 5;
        if (sel == 2) return (c + 2) / 4;
        return 0;
    endfunction

    task automatic run_to_lock(input int p, output int lat, output int mism);
        int prev;
        int alt;
        bit have_prev;
        bit pdir;
        bit mlock;
        bit dir;
        prev = int'(period_code);
        alt = 0;
        have_prev = 0;
        pdir = 0;
        mlock = 0;
        mism = 0;
        lat = -1;
        for (int c = 1; c <= 300; c++) begin
            @(negedge clk);
            if (int'(period_code) != prev) begin
                dir = int'(period_code) > prev;
                if (have_prev && dir != pdir) alt++;
                else alt = 0;
                have_prev = 1;
                pdir = dir;
                prev = int'(period_code);
                if (alt >= 4) mlock = 1;
            end
            if (locked != mlock) mism++;
            if (locked) begin
                lat = c;
                break;
            end
        end
    endtask

    initial begin
        cycles(190000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        finish_run();
    end

    initial begin
        int lat;
        int mism;
        int held;
        int c;

        // R1 reset state
        cycles(3);
        check(period_code == 0, "R1 code in reset", int'(period_code), 0);
        check(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        check(bypass == 1'b1, "R8 bypass at 0 deg", int'(bypass), 1);
        rst = 1'b0;
        @(negedge clk);
        check(period_code == 0, "R1 code after reset", int'(period_code), 0);
        check(locked == 1'b0, "R1 locked after reset", int'(locked), 0);

        // R2 update rate and step direction
        do_reset();
        target = 40;
        enable = 1'b1;
        cycles(1);
        check(period_code == 0, "R2 no update before interval", int'(period_code), 0);
        cycles(19);
        check(period_code == 10, "R2 code after 20 cycles", int'(period_code), 10);
        cycles(1);
        check(period_code == 10, "R2 code after 21 cycles", int'(period_code), 10);
        target = 0;
        cycles(2);
        check(period_code == 9, "R2 down step", int'(period_code), 9);

        // R4 R5 R8 R9 sweep over every target
        for (int p = 1; p < 64; p++) begin
            do_reset();
            target = p;
            enable = 1'b1;
            run_to_lock(p, lat, mism);
            check(lat > 0 && lat <= 256, "R4 lock latency", lat, 256);
            check(int'(period_code) == p || int'(period_code) == p - 1,
                  "R4 locked code", int'(period_code), p);
            check(mism == 0, "R5 lock timing vs reversal count", mism, 0);
            freeze = 1'b1;
            cycles(2);
            held = int'(period_code);
            for (int s = 0; s < 4; s++) begin
                phase_sel = 2'(s);
                @(negedge clk);
                for (int l = 0; l < NS; l++) begin
                    c = int'(shift_codes[l*W +: W]);
                    check(c == exp_shift(held, s), "R9 R8 lane shift", c, exp_shift(held, s));
                end
                check(bypass == (s == 0 || s == 3), "R8 bypass flag", int'(bypass),
                      int'(s == 0 || s == 3));
            end
            check(int'(period_code) == held, "R7 code held while frozen", int'(period_code), held);
            freeze = 1'b0;
            phase_sel = 2'b00;
        end

        // R5 sticky lock and R7 freeze with target move
        do_reset();
        target = 30;
        enable = 1'b1;
        run_to_lock(30, lat, mism);
        cycles(20);
        check(locked == 1'b1, "R5 lock sticky", int'(locked), 1);
        freeze = 1'b1;
        cycles(1);
        held = int'(period_code);
        target = 10;
        cycles(20);
        check(int'(period_code) == held, "R7 frozen code", int'(period_code), held);
        check(locked == 1'b1, "R7 frozen lock", int'(locked), 1);
        freeze = 1'b0;
        cycles(80);
        check(period_code == 10 || period_code == 9, "R7 resume tracking", int'(period_code), 10);

        // R6 enable low
        enable = 1'b0;
        held = int'(period_code);
        cycles(1);
        check(locked == 1'b0, "R6 lock cleared", int'(locked), 0);
        target = 50;
        cycles(10);
        check(int'(period_code) == held, "R6 code held", int'(period_code), held);
        enable = 1'b1;
        cycles(4);
        check(locked == 1'b0, "R6 lock restarts", int'(locked), 0);
        check(int'(period_code) == held + 2, "R6 tracking resumes", int'(period_code), held + 2);

        // R3 saturation
        do_reset();
        target = 100;
        enable = 1'b1;
        cycles(200);
        check(period_code == 63, "R3 saturate high", int'(period_code), 63);
        check(locked == 1'b0, "R3 no lock at high rail", int'(locked), 0);
        target = 0;
        cycles(200);
        check(period_code == 0, "R3 saturate low", int'(period_code), 0);
        check(locked == 1'b0, "R3 no lock at low rail", int'(locked), 0);

        finish_run();
    end

endmodule